// File: doc/BRIEF.md
# Host-Bus to Peripheral Handshake Sequencer

This block sits between a host bus and an external peripheral. The host starts a transfer by raising either a read request or a write request. The block then runs a four-phase strobe/acknowledge exchange with the device. It enables the data transceiver at the correct points and returns an acknowledge to the host. The two handshakes are interleaved in a fixed order that differs between reads and writes. In both cycle types, the host acknowledge and the device strobe are released together during the return-to-zero phase.

The block is a clocked state machine. The two host requests and the device acknowledge pass through two-flop synchronizers before the state machine uses them. Every output comes from a register. During a read, two points in the cycle show the same visible values on (read request, host acknowledge, device acknowledge, device strobe, transceiver enable). At one of them the strobe is about to rise, and at the other it is about to fall. An internal marker bit (`seq_mark`, brought out for observation) tells these two points apart. It is set just after the device acknowledges and is cleared once the device acknowledge has returned low.

Two events are protocol faults: the device acknowledge moving out of order, and both host requests being high at the same time. On a fault the block enters a sticky fault state, raises `proto_err` and freezes every output until reset.

States and transitions:
- `IDLE` goes to `RD_STROBE` on a read request and to `WR_ENABLE` on a write request.
- The read path is `RD_STROBE` → `RD_MARK` (device acknowledged) → `RD_ENABLE` → `RD_ACK` → `RD_DROP_EN` (read request low) → `RD_RELEASE` → `IDLE` (device acknowledge low).
- The write path is `WR_ENABLE` → `WR_STROBE` → `WR_DROP_EN` (device acknowledged) → `WR_ACK` → `WR_RELEASE` (write request low) → `IDLE` (device acknowledge low).
- Any state goes to `FAULT` on a protocol fault, and `FAULT` is left only by reset.

Top module: `hs_ctrl`

## Requirements
- R1: A synchronous active-low reset clears host_ack, dev_strobe, xcvr_en, seq_mark and proto_err and leaves the block in IDLE.
- R2: A change on any request or on the device acknowledge, applied between clock edges, can first change an output at the third rising edge after it (two synchronizer flops plus the output register).
- R3: A read proceeds one edge at a time as: dev_strobe rises, then (after dev_ack_in high) seq_mark rises, then xcvr_en rises, then host_ack rises.
- R4: After the read request falls, xcvr_en falls first, and on the next edge host_ack and dev_strobe fall together.
- R5: seq_mark rises only while dev_strobe is high and xcvr_en is low. It falls one edge after the synchronized dev_ack_in is seen low following the release. It is never set during a write.
- R6: A write proceeds as: xcvr_en rises, then dev_strobe rises, then (after dev_ack_in high) xcvr_en falls, then host_ack rises on the next edge.
- R7: After the write request falls, host_ack and dev_strobe fall together, and the block returns to IDLE once dev_ack_in is low.
- R8: dev_strobe never rises while the synchronized dev_ack_in is high. A request held high during the release phase starts a new cycle only after dev_ack_in returns low.
- R9: Both requests seen high together set proto_err.
- R10: dev_ack_in seen high in IDLE or before the write strobe, or seen low while a read or write holds the strobe after acknowledgement (before release), sets proto_err.
- R11: Once proto_err is set, it and all other outputs hold their values, whatever the inputs do, until reset.
- R12: Once a read has been acknowledged by the device, the cycle completes through host_ack high even if the read request is withdrawn early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd_req | input | 1 | Host read request (asynchronous) |
| host_wr_req | input | 1 | Host write request (asynchronous) |
| dev_ack_in | input | 1 | Device acknowledge (asynchronous) |
| host_ack | output | 1 | Transfer acknowledge to host |
| dev_strobe | output | 1 | Strobe to the device |
| xcvr_en | output | 1 | Data transceiver enable |
| seq_mark | output | 1 | Internal marker bit separating look-alike read states |
| proto_err | output | 1 | Sticky protocol fault flag |

## Verification
Full read cycles and full write cycles tell the two event orderings apart. They also show that the marker appears only in reads. A read whose request is withdrawn right after the device acknowledges shows that an enabled acknowledge is never dropped. A request that is re-raised while the device acknowledge is still high shows that the next strobe waits for the device to return low. Device acknowledges injected in idle and in mid-cycle, together with simultaneous read and write requests, separate legal waiting from fault detection and show that the fault freezes the outputs.

// File: rtl/hs_ctrl_pkg.sv
package hs_ctrl_pkg;

    typedef enum logic [3:0] {
        IDLE,
        RD_STROBE,
        RD_MARK,
        RD_ENABLE,
        RD_ACK,
        RD_DROP_EN,
        RD_RELEASE,
        WR_ENABLE,
        WR_STROBE,
        WR_DROP_EN,
        WR_ACK,
        WR_RELEASE,
        FAULT
    } hs_state_e;

    typedef struct packed {
        logic ack;
        logic strobe;
        logic en;
        logic mark;
    } hs_out_t;

    function automatic hs_out_t decode_outputs(hs_state_e s);
        hs_out_t o;
        o = '0;
        unique case (s)
            RD_STROBE:  o = '{ack: 1'b0, strobe: 1'b1, en: 1'b0, mark: 1'b0};
            RD_MARK:    o = '{ack: 1'b0, strobe: 1'b1, en: 1'b0, mark: 1'b1};
            RD_ENABLE:  o = '{ack: 1'b0, strobe: 1'b1, en: 1'b1, mark: 1'b1};
            RD_ACK:     o = '{ack: 1'b1, strobe: 1'b1, en: 1'b1, mark: 1'b1};
            RD_DROP_EN: o = '{ack: 1'b1, strobe: 1'b1, en: 1'b0, mark: 1'b1};
            RD_RELEASE: o = '{ack: 1'b0, strobe: 1'b0, en: 1'b0, mark: 1'b1};
            WR_ENABLE:  o = '{ack: 1'b0, strobe: 1'b0, en: 1'b1, mark: 1'b0};
            WR_STROBE:  o = '{ack: 1'b0, strobe: 1'b1, en: 1'b1, mark: 1'b0};
            WR_DROP_EN: o = '{ack: 1'b0, strobe: 1'b1, en: 1'b0, mark: 1'b0};
            WR_ACK:     o = '{ack: 1'b1, strobe: 1'b1, en: 1'b0, mark: 1'b0};
            default:    o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= '0;
                end else begin
                    if (g == 0) chain[g] <= async_in;
                    else        chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[LAST];
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
    import hs_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ack_s,
    output logic host_ack,
    output logic dev_strobe,
    output logic xcvr_en,
    output logic seq_mark,
    output logic proto_err
);
    hs_state_e state_q, state_d;
    hs_out_t   nxt_out;

    always_comb begin
        state_d = state_q;
        if (state_q != FAULT && rd_s && wr_s) begin
            state_d = FAULT;
        end else begin
            unique case (state_q)
                IDLE: begin
                    if (ack_s)     state_d = FAULT;
                    else if (rd_s) state_d = RD_STROBE;
                    else if (wr_s) state_d = WR_ENABLE;
                end
                RD_STROBE:  if (ack_s) state_d = RD_MARK;
                RD_MARK:    state_d = ack_s ? RD_ENABLE : FAULT;
                RD_ENABLE:  state_d = ack_s ? RD_ACK : FAULT;
                RD_ACK: begin
                    if (!ack_s)    state_d = FAULT;
                    else if (!rd_s) state_d = RD_DROP_EN;
                end
                RD_DROP_EN: state_d = ack_s ? RD_RELEASE : FAULT;
                RD_RELEASE: if (!ack_s) state_d = IDLE;
                WR_ENABLE:  state_d = ack_s ? FAULT : WR_STROBE;
                WR_STROBE:  if (ack_s) state_d = WR_DROP_EN;
                WR_DROP_EN: state_d = ack_s ? WR_ACK : FAULT;
                WR_ACK: begin
                    if (!ack_s)     state_d = FAULT;
                    else if (!wr_s) state_d = WR_RELEASE;
                end
                WR_RELEASE: if (!ack_s) state_d = IDLE;
                FAULT:      state_d = FAULT;
                default:    state_d = FAULT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    assign nxt_out = decode_outputs(state_d);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ack   <= 1'b0;
            dev_strobe <= 1'b0;
            xcvr_en    <= 1'b0;
            seq_mark   <= 1'b0;
            proto_err  <= 1'b0;
        end else if (state_d == FAULT) begin
            proto_err  <= 1'b1;
        end else begin
            host_ack   <= nxt_out.ack;
            dev_strobe <= nxt_out.strobe;
            xcvr_en    <= nxt_out.en;
            seq_mark   <= nxt_out.mark;
        end
    end

    // R3 / R6: host acknowledge only after the device has acknowledged
    p_ack_after_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> dev_strobe && $past(ack_s));

    // R8: strobe never launched while device acknowledge is high
    p_strobe_needs_idle_dev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_strobe) |-> !$past(ack_s));

    // R5: marker set only inside the strobe window before the enable
    p_mark_set_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_mark) |-> dev_strobe && !xcvr_en);

    // R5: marker cleared only after device acknowledge has dropped
    p_mark_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_mark) |-> !$past(ack_s) && !dev_strobe);

    // R9: conflicting requests force the fault flag
    p_dual_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && wr_s) |=> proto_err);

    // R11: fault is sticky and freezes outputs
    p_fault_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err && $stable({host_ack, dev_strobe, xcvr_en, seq_mark}));
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rd_req,
    input  logic host_wr_req,
    input  logic dev_ack_in,
    output logic host_ack,
    output logic dev_strobe,
    output logic xcvr_en,
    output logic seq_mark,
    output logic proto_err
);
    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] raw_in, clean_in;

    assign raw_in = {host_rd_req, host_wr_req, dev_ack_in};

    hs_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (clean_in)
    );

    hs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_s       (clean_in[2]),
        .wr_s       (clean_in[1]),
        .ack_s      (clean_in[0]),
        .host_ack   (host_ack),
        .dev_strobe (dev_strobe),
        .xcvr_en    (xcvr_en),
        .seq_mark   (seq_mark),
        .proto_err  (proto_err)
    );
endmodule

// File: tb/sim_hs_ctrl.sv
module sim_hs_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0, wr = 1'b0, dack = 1'b0;
    logic host_ack, dev_strobe, xcvr_en, seq_mark, proto_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hs_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .host_rd_req(rd), .host_wr_req(wr), .dev_ack_in(dack),
        .host_ack(host_ack), .dev_strobe(dev_strobe), .xcvr_en(xcvr_en),
        .seq_mark(seq_mark), .proto_err(proto_err)
    );

    // ---------------- behavioural reference model ----------------
    // mode 0 idle, 1 read, 2 write; step indexes the event list below
    int   m_mode = 0, m_step = 0;
    logic m_err = 1'b0;
    logic [3:0] m_out = 4'b0;       // {ack, strobe, en, mark}
    logic [2:0] p1 = '0, p2 = '0;   // delayed {rd, wr, ack}

    function automatic logic [3:0] read_vec(int s);
        logic [3:0] v [7] = '{4'b0000, 4'b0100, 4'b0101, 4'b0111, 4'b1111, 4'b1101, 4'b0001};
        return v[s];
    endfunction

    function automatic logic [3:0] write_vec(int s);
        logic [3:0] v [6] = '{4'b0000, 4'b0010, 4'b0110, 4'b0100, 4'b1100, 4'b0000};
        return v[s];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_step = 0; m_err = 1'b0; m_out = 4'b0;
            p1 = '0; p2 = '0;
        end else begin
            logic r, w, a, bad;
            int nm, ns;
            r = p2[2]; w = p2[1]; a = p2[0];
            nm = m_mode; ns = m_step; bad = r && w;
            if (!m_err) begin
                if (m_mode == 0) begin
                    if (a) bad = 1'b1;
                    else if (r) begin nm = 1; ns = 1; end
                    else if (w) begin nm = 2; ns = 1; end
                end else if (m_mode == 1) begin
                    if (m_step == 1) begin if (a) ns = 2; end
                    else if (m_step == 6) begin if (!a) begin nm = 0; ns = 0; end end
                    else if (!a) bad = 1'b1;
                    else if (m_step != 4 || !r) ns = m_step + 1;
                end else begin
                    if (m_step == 1) begin if (a) bad = 1'b1; else ns = 2; end
                    else if (m_step == 2) begin if (a) ns = 3; end
                    else if (m_step == 5) begin if (!a) begin nm = 0; ns = 0; end end
                    else if (!a) bad = 1'b1;
                    else if (m_step != 4 || !w) ns = m_step + 1;
                end
                if (bad) m_err = 1'b1;
                else begin
                    m_mode = nm; m_step = ns;
                    m_out = (nm == 1) ? read_vec(ns) : (nm == 2) ? write_vec(ns) : 4'b0;
                end
            end
            p2 = p1;
            p1 = {rd, wr, dack};
        end
    end

    function automatic string phase_req();
        if (m_err) return "R11";
        if (m_mode == 1) return (m_step >= 5) ? "R4" : "R3";
        if (m_mode == 2) return (m_step >= 5) ? "R7" : "R6";
        return "R8";
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if ({host_ack, dev_strobe, xcvr_en, seq_mark, proto_err} !== {m_out, m_err}) begin
                failures++;
                $display("FAIL %s model compare: actual=%b expected=%b", phase_req(),
                         {host_ack, dev_strobe, xcvr_en, seq_mark, proto_err}, {m_out, m_err});
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic get_out(input int which);
        case (which)
            0: return host_ack;
            1: return dev_strobe;
            2: return xcvr_en;
            3: return seq_mark;
            default: return proto_err;
        endcase
    endfunction

    task automatic wait_out(input int which, input logic val, input string req);
        for (int i = 0; i < 40; i++) begin
            if (get_out(which) === val) return;
            @(negedge clk);
        end
        chk(1'b0, req, "timeout waiting for output", get_out(which), val);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rd = 1'b0; wr = 1'b0; dack = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit saw_ack;
        do_reset();
        // r1_ reset state
        chk({host_ack, dev_strobe, xcvr_en, seq_mark, proto_err} == 5'b0, "R1", "outputs after reset",
            {host_ack, dev_strobe, xcvr_en, seq_mark, proto_err}, 0);

        // full read with latency probe
        rd = 1'b1;
        tick(2);
        chk(dev_strobe == 1'b0, "R2", "strobe before third edge", dev_strobe, 0);
        tick(1);
        chk(dev_strobe == 1'b1, "R2", "strobe at third edge", dev_strobe, 1);
        chk(seq_mark == 1'b0 && xcvr_en == 1'b0, "R3", "only strobe first", {seq_mark, xcvr_en}, 0);
        dack = 1'b1;
        wait_out(3, 1'b1, "R5");
        chk(xcvr_en == 1'b0 && dev_strobe == 1'b1, "R5", "mark rises before enable", {dev_strobe, xcvr_en}, 2);
        tick(1);
        chk(xcvr_en == 1'b1 && host_ack == 1'b0, "R3", "enable before ack", {xcvr_en, host_ack}, 2);
        tick(1);
        chk(host_ack == 1'b1, "R3", "ack after enable", host_ack, 1);
        rd = 1'b0;
        wait_out(2, 1'b0, "R4");
        chk(host_ack == 1'b1 && dev_strobe == 1'b1, "R4", "ack/strobe held while enable drops", {host_ack, dev_strobe}, 3);
        tick(1);
        chk(host_ack == 1'b0 && dev_strobe == 1'b0 && seq_mark == 1'b1, "R4", "joint release",
            {host_ack, dev_strobe, seq_mark}, 1);
        dack = 1'b0;
        tick(3);
        chk(seq_mark == 1'b0, "R5", "mark cleared after device release", seq_mark, 0);

        // full write
        tick(2);
        wr = 1'b1;
        tick(3);
        chk(xcvr_en == 1'b1 && dev_strobe == 1'b0, "R6", "enable before strobe", {xcvr_en, dev_strobe}, 2);
        tick(1);
        chk(dev_strobe == 1'b1, "R6", "strobe after enable", dev_strobe, 1);
        dack = 1'b1;
        wait_out(2, 1'b0, "R6");
        chk(host_ack == 1'b0, "R6", "ack waits for enable drop", host_ack, 0);
        tick(1);
        chk(host_ack == 1'b1 && seq_mark == 1'b0, "R6", "ack after enable drop, no mark (R5)", {host_ack, seq_mark}, 2);
        wr = 1'b0;
        wait_out(0, 1'b0, "R7");
        chk(dev_strobe == 1'b0, "R7", "strobe released with ack", dev_strobe, 0);
        dack = 1'b0;
        tick(4);
        chk({host_ack, dev_strobe, xcvr_en, seq_mark, proto_err} == 5'b0, "R7", "idle after write",
            {host_ack, dev_strobe, xcvr_en, seq_mark, proto_err}, 0);

        // r12_ early withdrawal of read request
        rd = 1'b1;
        wait_out(1, 1'b1, "R12");
        dack = 1'b1;
        tick(1);
        rd = 1'b0;
        saw_ack = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (host_ack) saw_ack = 1'b1;
        end
        chk(saw_ack, "R12", "ack completed after early withdrawal", saw_ack, 1);
        dack = 1'b0;
        tick(4);

        // r8_ request re-raised while device still acknowledging
        rd = 1'b1;
        wait_out(1, 1'b1, "R8");
        dack = 1'b1;
        wait_out(0, 1'b1, "R8");
        rd = 1'b0;
        wait_out(1, 1'b0, "R8");
        rd = 1'b1;
        tick(6);
        chk(dev_strobe == 1'b0, "R8", "no strobe while device ack high", dev_strobe, 0);
        dack = 1'b0;
        tick(3);
        chk(dev_strobe == 1'b0 && seq_mark == 1'b0, "R8", "idle one edge first", {dev_strobe, seq_mark}, 0);
        tick(1);
        chk(dev_strobe == 1'b1, "R8", "new cycle starts", dev_strobe, 1);
        dack = 1'b1;
        wait_out(0, 1'b1, "R8");
        rd = 1'b0;
        wait_out(1, 1'b0, "R8");
        dack = 1'b0;
        tick(4);

        // r10_ stray device acknowledge in idle
        dack = 1'b1;
        tick(3);
        chk(proto_err == 1'b1 && dev_strobe == 1'b0, "R10", "stray ack in idle", {proto_err, dev_strobe}, 2);
        rd = 1'b1;
        tick(5);
        chk(proto_err == 1'b1 && dev_strobe == 1'b0, "R11", "fault holds outputs", {proto_err, dev_strobe}, 2);
        do_reset();
        chk(proto_err == 1'b0, "R1", "reset clears fault", proto_err, 0);

        // r10_ device acknowledge dropped mid-read
        rd = 1'b1;
        wait_out(1, 1'b1, "R10");
        dack = 1'b1;
        wait_out(0, 1'b1, "R10");
        dack = 1'b0;
        tick(3);
        chk(proto_err == 1'b1 && {host_ack, dev_strobe, xcvr_en, seq_mark} == 4'b1111, "R10",
            "early device release", {proto_err, host_ack, dev_strobe, xcvr_en, seq_mark}, 31);
        rd = 1'b0;
        tick(5);
        chk({host_ack, dev_strobe, xcvr_en, seq_mark, proto_err} == 5'b11111, "R11", "outputs frozen",
            {host_ack, dev_strobe, xcvr_en, seq_mark, proto_err}, 31);
        do_reset();

        // r9_ conflicting requests
        rd = 1'b1; wr = 1'b1;
        tick(3);
        chk(proto_err == 1'b1 && dev_strobe == 1'b0 && xcvr_en == 1'b0, "R9", "both requests",
            {proto_err, dev_strobe, xcvr_en}, 4);
        do_reset();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule